// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the slave side of a 512-byte serial EEPROM that a host reaches over a four-wire SPI link. It oversamples chip select, serial clock, data in and the write-protect pin on the system clock. It decodes one-byte instructions and keeps the protection state: a write-enable latch and two block-protect bits. The storage array is an internal register array, reset to all ones.

A write is buffered into a 16-byte page register and is committed only when chip select is released cleanly on a byte boundary. A parameterised busy window then follows, in which the buffered bytes or the new protect bits are stored. During that window the host can poll the status byte, but array and status-write traffic is refused. Reads return bytes back to back with an advancing address, for as long as the host keeps clocking.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges, MSB first. Output bits change after falling edges, MSB first. The serial clock may idle low (mode 0) or idle high (mode 3).
- R2: The opcode is 0000_xNNN. The low three bits select the command: 110 sets the enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array. Bit 3 carries address bit 8 for the two array commands and is ignored by the others.
- R3: A byte with a nonzero upper nibble, or with low bits 000 or 111, is illegal. After an illegal byte, everything up to the next chip-select release has no effect, and data out stays 0.
- R4: The status byte is {1,1,1,1,protect[1],protect[0],enable,busy} and reads 8'hF0 after reset.
- R5: The enable latch is 0 after reset. Array writes and status writes are refused while it is 0.
- R6: A write is committed only if chip select rises after a whole number of data bytes, with at least one byte for an array write. A rise after a partial byte discards the write and leaves busy at 0.
- R7: Protect value 00 guards nothing, 01 guards 180h-1FFh, 10 guards 100h-1FFh and 11 guards the whole array. A write aimed at a guarded page is discarded and does not start a busy window.
- R8: While the write-protect pin is low, array and status writes are discarded. Reads still work.
- R9: Busy holds for WRITE_CYCLES system clocks after a commit. While busy, array reads return 0, and array and status writes are ignored. Status reads keep working.
- R10: A page write fills 16 bytes at most. The low four address bits wrap inside the page, so the 17th and later bytes overwrite earlier bytes of the same page.
- R11: At the end of the busy window, busy and the enable latch both clear in the same clock.
- R12: An array read streams consecutive bytes and wraps from 1FFh to 000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data from the host |
| wpN | input | 1 | Active-low write protect |
| miso | output | 1 | Serial data to the host, 0 when not driving |

## Verification
The situations hardest to reach from the pins are a write whose chip-select release comes a few bits past a byte boundary, and instructions that land inside the busy window. The bench has a task that clocks a chosen number of loose bits before release. It also sets WRITE_CYCLES long enough that a read and a write attempt both fit inside the window, before status polling shows the window close. Block protection is swept over all four settings against addresses on each side of every guarded boundary, and the SPI mode alternates from one setting to the next.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int ADDR_W     = 9;
  localparam int DATA_W     = 8;
  localparam int PAGE_W     = 4;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MEM_DEPTH  = 1 << ADDR_W;
  localparam int HI_W       = ADDR_W - DATA_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int BIT_W      = $clog2(DATA_W);

  localparam logic [2:0] CMD_SET_WEL = 3'b110;
  localparam logic [2:0] CMD_CLR_WEL = 3'b100;
  localparam logic [2:0] CMD_RD_STAT = 3'b101;
  localparam logic [2:0] CMD_WR_STAT = 3'b001;
  localparam logic [2:0] CMD_RD_MEM  = 3'b011;
  localparam logic [2:0] CMD_WR_MEM  = 3'b010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPCODE, ST_ADDR, ST_WDATA, ST_RDATA,
    ST_SRDATA, ST_SRDONE, ST_STATUS, ST_IGNORE
  } ctrlStateT;

  typedef struct packed {
    logic              setWel;
    logic              clrWel;
    logic              readFirst;
    logic              readNext;
    logic              stageStatus;
    logic              openPage;
    logic              bufWrite;
    logic              latchSr;
    logic              startWrite;
    logic              startSr;
    logic              shiftOut;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } ctrlStrobeT;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csHigh,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       mosiS,
  input  logic       wip,
  input  logic       wel,
  output ctrlStrobeT stb,
  output logic       driveOut
);
  ctrlStateT         state, stateNext;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-2:0] shiftIn;
  logic              isRead, isReadNext;
  logic [HI_W-1:0]   addrHi, addrHiNext;
  logic              gotByte, gotNext;
  logic [DATA_W-1:0] byteIn;
  logic              byteDone;

  assign byteIn   = {shiftIn, mosiS};
  assign byteDone = sclkRise && (bitCnt == BIT_W'(DATA_W - 1));
  assign driveOut = (state == ST_RDATA) || (state == ST_STATUS);

  always_comb begin
    stb          = '0;
    stb.shiftOut = sclkFall;
    stb.addr     = {addrHi, byteIn};
    stb.data     = byteIn;
    stateNext    = state;
    isReadNext   = isRead;
    addrHiNext   = addrHi;
    gotNext      = gotByte;
    if (csFall) begin
      stateNext = ST_OPCODE;
    end else if (csRise) begin
      if (state == ST_WDATA && bitCnt == '0 && gotByte) stb.startWrite = 1'b1;
      if (state == ST_SRDONE && bitCnt == '0) stb.startSr = 1'b1;
      stateNext = ST_IDLE;
    end else if (sclkRise && state == ST_SRDONE) begin
      stateNext = ST_IGNORE;
    end else if (byteDone) begin
      case (state)
        ST_OPCODE: begin
          stateNext = ST_IGNORE;
          if (byteIn[7:4] == 4'b0000) begin
            case (byteIn[2:0])
              CMD_SET_WEL: stb.setWel = 1'b1;
              CMD_CLR_WEL: stb.clrWel = 1'b1;
              CMD_RD_STAT: begin
                stb.stageStatus = 1'b1;
                stateNext = ST_STATUS;
              end
              CMD_WR_STAT: if (!wip && wel) stateNext = ST_SRDATA;
              CMD_RD_MEM: if (!wip) begin
                addrHiNext = byteIn[3];
                isReadNext = 1'b1;
                stateNext  = ST_ADDR;
              end
              CMD_WR_MEM: if (!wip && wel) begin
                addrHiNext = byteIn[3];
                isReadNext = 1'b0;
                stateNext  = ST_ADDR;
              end
              default: stateNext = ST_IGNORE;
            endcase
          end
        end
        ST_ADDR: begin
          if (isRead) begin
            stb.readFirst = 1'b1;
            stateNext = ST_RDATA;
          end else begin
            stb.openPage = 1'b1;
            gotNext = 1'b0;
            stateNext = ST_WDATA;
          end
        end
        ST_WDATA: begin
          stb.bufWrite = 1'b1;
          gotNext = 1'b1;
        end
        ST_RDATA:  stb.readNext = 1'b1;
        ST_STATUS: stb.stageStatus = 1'b1;
        ST_SRDATA: begin
          stb.latchSr = 1'b1;
          stateNext = ST_SRDONE;
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shiftIn <= '0;
      isRead  <= 1'b0;
      addrHi  <= '0;
      gotByte <= 1'b0;
    end else begin
      state   <= stateNext;
      isRead  <= isReadNext;
      addrHi  <= addrHiNext;
      gotByte <= gotNext;
      if (csFall) bitCnt <= '0;
      else if (sclkRise && state != ST_IDLE) bitCnt <= bitCnt + 1'b1;
      if (sclkRise) shiftIn <= byteIn[DATA_W-2:0];
    end
  end

  // R3: once locked out, only a chip-select release leaves the lockout
  assert_lockout_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && !csHigh) |=> (state == ST_IGNORE));

  // R6: a commit strobe is only raised on the cycle chip select is released
  assert_commit_on_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startWrite || stb.startSr) |-> (csHigh && !$past(csHigh)));
endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT stb,
  input  logic       driveOut,
  input  logic       wpS,
  output logic       wip,
  output logic       wel,
  output logic       miso
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0] mem     [MEM_DEPTH];
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [PG_W-1:0]   wrPage;
  logic [PAGE_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdAddr;
  logic [1:0]        bp, srNew;
  logic [DATA_W-1:0] outShift, outStage, statusByte;
  logic              stagePend, commitSr;
  logic [CNT_W-1:0]  wipCnt;
  logic [1:0]        pageTop;
  logic              pageProt;

  assign statusByte = {4'hF, bp, wel, wip};
  assign pageTop    = wrPage[PG_W-1 -: 2];
  assign pageProt   = (bp == 2'b11) || (bp == 2'b10 && pageTop[1])
                   || (bp == 2'b01 && pageTop == 2'b11);
  assign miso       = driveOut & outShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '1;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
      bufValid  <= '0;
      wrPage    <= '0;
      wrPtr     <= '0;
      rdAddr    <= '0;
      bp        <= '0;
      srNew     <= '0;
      outShift  <= '0;
      outStage  <= '0;
      stagePend <= 1'b0;
      commitSr  <= 1'b0;
      wipCnt    <= '0;
      wip       <= 1'b0;
      wel       <= 1'b0;
    end else begin
      if (stb.setWel) wel <= 1'b1;
      if (stb.clrWel) wel <= 1'b0;
      if (stb.openPage) begin
        wrPage   <= stb.addr[ADDR_W-1:PAGE_W];
        wrPtr    <= stb.addr[PAGE_W-1:0];
        bufValid <= '0;
      end
      if (stb.bufWrite) begin
        pageBuf[wrPtr]  <= stb.data;
        bufValid[wrPtr] <= 1'b1;
        wrPtr           <= wrPtr + 1'b1;
      end
      if (stb.latchSr) srNew <= stb.data[3:2];
      if (stb.startWrite && wpS && !pageProt) begin
        wip      <= 1'b1;
        wipCnt   <= CNT_W'(WRITE_CYCLES);
        commitSr <= 1'b0;
      end
      if (stb.startSr && wpS) begin
        wip      <= 1'b1;
        wipCnt   <= CNT_W'(WRITE_CYCLES);
        commitSr <= 1'b1;
      end
      if (wip) begin
        if (wipCnt == CNT_W'(1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
          if (commitSr) bp <= srNew;
          else begin
            for (int i = 0; i < PAGE_BYTES; i++)
              if (bufValid[i]) mem[{wrPage, PAGE_W'(i)}] <= pageBuf[i];
          end
        end else begin
          wipCnt <= wipCnt - 1'b1;
        end
      end
      if (stb.readFirst) begin
        outStage  <= mem[stb.addr];
        rdAddr    <= stb.addr + 1'b1;
        stagePend <= 1'b1;
      end else if (stb.readNext) begin
        outStage  <= mem[rdAddr];
        rdAddr    <= rdAddr + 1'b1;
        stagePend <= 1'b1;
      end else if (stb.stageStatus) begin
        outStage  <= statusByte;
        stagePend <= 1'b1;
      end else if (stb.shiftOut) begin
        if (stagePend) begin
          outShift  <= outStage;
          stagePend <= 1'b0;
        end else begin
          outShift <= {outShift[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // R9: no buffering, reading or status capture while busy
  assert_busy_locks_R9: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !(stb.bufWrite || stb.readFirst || stb.latchSr));

  // R9: a new array commit never arrives inside a busy window
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.startWrite |-> !wip);

  // R5: commits are only requested with the enable latch set
  assert_commit_needs_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startWrite || stb.startSr) |-> wel);

  // R11: the enable latch is clear once busy falls
  assert_wel_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  // R8: busy only starts from a commit request made with the pin high
  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> ($past(stb.startWrite || stb.startSr) && $past(wpS)));
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  input  logic wpN,
  output logic miso
);
  logic csMeta, csS, csD;
  logic sclkMeta, sclkS, sclkD;
  logic mosiMeta, mosiS;
  logic wpMeta, wpS;
  logic csFall, csRise, sclkRise, sclkFall;
  logic wip, wel, driveOut;
  ctrlStrobeT stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {csMeta, csS, csD}       <= 3'b111;
      {sclkMeta, sclkS, sclkD} <= 3'b000;
      {mosiMeta, mosiS}        <= 2'b00;
      {wpMeta, wpS}            <= 2'b00;
    end else begin
      {csMeta, csS, csD}       <= {csN, csMeta, csS};
      {sclkMeta, sclkS, sclkD} <= {sclk, sclkMeta, sclkS};
      {mosiMeta, mosiS}        <= {mosi, mosiMeta};
      {wpMeta, wpS}            <= {wpN, wpMeta};
    end
  end

  assign csFall   = csD & ~csS;
  assign csRise   = ~csD & csS;
  assign sclkRise = sclkS & ~sclkD & ~csS;
  assign sclkFall = ~sclkS & sclkD & ~csS;

  eeprom_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csS), .csFall(csFall), .csRise(csRise),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .mosiS(mosiS),
    .wip(wip), .wel(wel), .stb(stb), .driveOut(driveOut)
  );

  eeprom_datapath #(.WRITE_CYCLES(WRITE_CYCLES)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .driveOut(driveOut), .wpS(wpS),
    .wip(wip), .wel(wel), .miso(miso)
  );
endmodule

// File: tb/test_spi_eeprom_ctrl.sv
module test_spi_eeprom_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int WCYC = 1000;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, mosi = 1'b0, wpN = 1'b1;
  logic miso;
  logic mode3 = 1'b0;
  int checks = 0, failures = 0;
  logic [7:0] model [512];
  logic [1:0] bpM = 2'b00;
  logic welM = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_ctrl #(.WRITE_CYCLES(WCYC)) i_spi_eeprom_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN), .miso(miso)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; mosi = tx[i]; waitClk(HALF);
      rx[i] = miso; sclk = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic looseBits(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; mosi = 1'b1; waitClk(HALF);
      sclk = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic sel();
    sclk = mode3; waitClk(HALF); csN = 1'b0; waitClk(HALF);
  endtask

  task automatic desel();
    if (!mode3) begin sclk = 1'b0; waitClk(HALF); end
    csN = 1'b1; waitClk(2*HALF);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] rx;
    sel(); xfer(op, rx); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] rx;
    sel(); xfer(8'h05, rx); xfer(8'h00, s); desel();
  endtask

  function automatic logic [7:0] expStat(input logic busy);
    return {4'hF, bpM, welM, busy};
  endfunction

  function automatic bit guarded(input logic [1:0] b, input int a);
    return (b == 2'b11) || (b == 2'b10 && a >= 256) || (b == 2'b01 && a >= 384);
  endfunction

  function automatic logic [7:0] dataOf(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic waitIdle(input string req);
    logic [7:0] s;
    int n = 0;
    do begin rdsr(s); n++; end while (s[0] && n < 40);
    check(!s[0], req, s, expStat(1'b0));
    check(s == expStat(1'b0), "R11", s, expStat(1'b0));
  endtask

  task automatic writeSeq(input int addr, input int n, input int seed, input string req);
    logic [7:0] rx, s;
    bit go;
    go = welM && wpN && !guarded(bpM, addr);
    sel();
    xfer({4'b0, 1'(addr >> 8), 3'b010}, rx);
    xfer(8'(addr), rx);
    for (int k = 0; k < n; k++) xfer(dataOf(seed, k), rx);
    desel();
    rdsr(s);
    check(s[0] == go, req, s[0], go);
    if (go) begin
      for (int k = 0; k < n; k++) model[(addr & 'h1F0) | ((addr + k) & 15)] = dataOf(seed, k);
      welM = 1'b0;
      waitIdle(req);
    end
  endtask

  task automatic readCheck(input int addr, input int n, input string req);
    logic [7:0] rx;
    sel();
    xfer({4'b0, 1'(addr >> 8), 3'b011}, rx);
    xfer(8'(addr), rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx);
      check(rx == model[(addr + k) & 511], req, rx, model[(addr + k) & 511]);
    end
    desel();
  endtask

  task automatic setProt(input logic [1:0] b);
    logic [7:0] rx;
    cmd1(8'h06); welM = 1'b1;
    sel(); xfer(8'h01, rx); xfer({4'b0, b, 2'b00}, rx); desel();
    if (wpN) begin bpM = b; welM = 1'b0; waitIdle("R7"); end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] s, rx;
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    waitClk(5); rstN = 1'b1; waitClk(5);

    rdsr(s); check(s == 8'hF0, "R4", s, 8'hF0);

    writeSeq('h045, 2, 1, "R5");
    readCheck('h045, 2, "R5");

    cmd1(8'h0E); welM = 1'b1;
    rdsr(s); check(s == expStat(1'b0), "R2", s, expStat(1'b0));
    cmd1(8'h0C); welM = 1'b0;
    rdsr(s); check(s == expStat(1'b0), "R5", s, expStat(1'b0));

    sel(); xfer(8'h07, rx); xfer(8'h06, rx); desel();
    rdsr(s); check(s == 8'hF0, "R3", s, 8'hF0);
    sel(); xfer(8'h16, rx); xfer(8'h06, rx); xfer(8'h05, rx); xfer(8'h00, rx); desel();
    check(rx == 8'h00, "R3", rx, 0);
    rdsr(s); check(s == 8'hF0, "R3", s, 8'hF0);

    cmd1(8'h06); welM = 1'b1;
    writeSeq('h045, 3, 2, "R2");
    cmd1(8'h06); welM = 1'b1;
    writeSeq('h145, 3, 3, "R2");
    readCheck('h045, 3, "R2");
    readCheck('h145, 3, "R2");

    cmd1(8'h06); welM = 1'b1;
    sel(); xfer(8'h02, rx); xfer(8'h60, rx); xfer(8'hA5, rx); looseBits(3); desel();
    rdsr(s); check(s == expStat(1'b0), "R6", s, expStat(1'b0));
    readCheck('h060, 1, "R6");

    writeSeq('h0FE, 18, 4, "R10");
    readCheck('h0F0, 16, "R10");

    cmd1(8'h06); welM = 1'b1;
    writeSeq('h1FE, 2, 5, "R12");
    cmd1(8'h06); welM = 1'b1;
    writeSeq('h000, 2, 6, "R12");
    readCheck('h1FE, 4, "R12");

    cmd1(8'h06); welM = 1'b1;
    sel(); xfer(8'h02, rx); xfer(8'h30, rx); xfer(8'h5A, rx); desel();
    model['h030] = 8'h5A;
    sel(); xfer(8'h03, rx); xfer(8'h30, rx); xfer(8'h00, rx); desel();
    check(rx == 8'h00, "R9", rx, 0);
    sel(); xfer(8'h02, rx); xfer(8'h31, rx); xfer(8'h77, rx); desel();
    rdsr(s); check(s == expStat(1'b1), "R9", s, expStat(1'b1));
    welM = 1'b0;
    waitIdle("R9");
    readCheck('h030, 2, "R9");

    wpN = 1'b0;
    cmd1(8'h06); welM = 1'b1;
    writeSeq('h070, 1, 7, "R8");
    readCheck('h070, 1, "R8");
    setProt(2'b11);
    rdsr(s); check(s == expStat(1'b0), "R8", s, expStat(1'b0));
    cmd1(8'h04); welM = 1'b0;
    wpN = 1'b1; waitClk(4);

    for (int b = 0; b < 4; b++) begin
      mode3 = b[0];
      setProt(2'(b));
      rdsr(s); check(s == expStat(1'b0), "R7", s, expStat(1'b0));
      for (int j = 0; j < 6; j++) begin
        int a;
        a = (j == 0) ? 'h000 : (j == 1) ? 'h0F0 : (j == 2) ? 'h100 :
            (j == 3) ? 'h170 : (j == 4) ? 'h180 : 'h1F0;
        cmd1(8'h06); welM = 1'b1;
        writeSeq(a, 2, 10 + b * 8 + j, "R7");
        readCheck(a, 2, mode3 ? "R1" : "R7");
        cmd1(8'h04); welM = 1'b0;
      end
    end
    mode3 = 1'b0;
    setProt(2'b00);
    rdsr(s); check(s == 8'hF0, "R7", s, 8'hF0);

    finishRun();
  end
endmodule